// File: doc/BRIEF.md
# Sensor Input De-Knee, Digital Gain and Line Delay

This block sits directly behind an external correlated-double-sampling, analog-gain and converter front end. It takes a stream of 10-bit sensor samples, one per cycle when valid, with a strobe marking the first pixel of every line. Each sample first passes an inverse-knee stage. Below a programmable knee point the sample passes unchanged. Above it, the excess over the knee point is scaled by one half. A digital gain from 1x to almost 16x follows, with saturation to the 10-bit full scale.

The gained sample is written into a one-line memory. In the same cycle, the sample stored at the same pixel index on the previous line is read back. Both values are presented together with their sum, so that downstream colour processing sees vertically adjacent pixels in step. A programmable active-pixel count limits how many pixels of each line are stored. Valid and line-start markers travel through a fixed four-cycle pipeline alongside the data.

Top module: `knee_gain_line`

## Requirements
- R1: While reset is held and after it is released, out_valid, out_sol, out_cur, out_prev and out_sum are all 0 until the first valid sample emerges.
- R2: A sample whose value is less than or equal to cfg_knee leaves the de-knee stage unchanged.
- R3: A sample x greater than cfg_knee leaves the de-knee stage as cfg_knee + floor((x - cfg_knee) / 2), so the curve has no step at the knee point.
- R4: cfg_gain is unsigned with 4 integer and 4 fractional bits. The gained value is min(1023, floor(d * cfg_gain / 16)), where d is the de-knee result, and it appears on out_cur.
- R5: cfg_gain codes below 16 (below 1x) act as code 16, so the sample passes at unity gain.
- R6: The pixel index counts valid samples from 0 at the line-start sample. out_prev equals the most recently stored out_cur value at the same index.
- R7: Pixels whose index is greater than or equal to cfg_active, or greater than or equal to 1024, are not stored, and they give out_prev = 0.
- R8: out_sum equals out_cur + out_prev as an 11-bit unsigned value whenever out_valid is high.
- R9: Every valid input produces exactly one out_valid pulse 4 clock edges later, with out_sol equal to the input's in_sol. Inputs with in_valid low produce no output, whatever in_data and in_sol carry.
- R10: A line-start on a valid sample restarts the index at 0 even if the previous line was short, so the next line reads back the short line's samples at the same indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_sol | input | 1 | First pixel of a line (qualified by in_valid) |
| in_data | input | 10 | Knee-compressed sensor sample |
| cfg_knee | input | 10 | Knee point of the inverse-knee curve |
| cfg_gain | input | 8 | Digital gain, unsigned 4.4 fixed point |
| cfg_active | input | 11 | Number of pixels per line stored in the line memory |
| out_valid | output | 1 | Output sample valid |
| out_sol | output | 1 | Line start, delayed with the data |
| out_cur | output | 10 | Current-line sample after de-knee and gain |
| out_prev | output | 10 | Sample at the same index on the previous line |
| out_sum | output | 11 | Sum of current and previous samples |

## Verification
Ramps across the whole input range, with a mid-scale knee, show that the two curve segments and their junction behave as specified. A knee at 0 and a knee at full scale exercise each segment alone. Random samples at unity gain, at sub-unity codes and at the maximum code separate plain scaling, clamping of small codes and saturation. Random lines of varying length, active count and idle gaps, plus a five-pixel line followed by a long line and two full 1024-pixel lines, show whether the index restarts correctly, whether stores stop at the active count and whether the memory wraps correctly at its depth.

// File: rtl/kgl_pkg.sv
package kgl_pkg;
  // Marker bits that travel with every pipeline stage.
  typedef struct packed {
    logic valid;
    logic sol;
  } kgl_tag_t;
endpackage

// File: rtl/kgl_inv_knee.sv
module kgl_inv_knee
  import kgl_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  kgl_tag_t      in_tag,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] knee,
  output kgl_tag_t      out_tag,
  output logic [DW-1:0] out_data
);
  logic          above;
  logic [DW-1:0] excess;
  logic [DW-1:0] mapped;

  always_comb begin
    above  = in_data > knee;
    excess = in_data - knee;
    mapped = above ? (knee + (excess >> 1)) : in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_tag  <= '0;
      out_data <= '0;
    end else begin
      out_tag  <= in_tag;
      out_data <= mapped;
    end
  end

  AST_KNEE_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_tag.valid && (in_data <= knee)) |=> (out_data == $past(in_data))); // R2

  AST_KNEE_HALF: assert property (@(posedge clk) disable iff (rst)
    (in_tag.valid && (in_data > knee)) |=>
      ((out_data <= $past(in_data)) && (out_data >= $past(knee)))); // R3
endmodule

// File: rtl/kgl_agc.sv
module kgl_agc
  import kgl_pkg::*;
#(
  parameter int DW     = 10,
  parameter int GW     = 8,
  parameter int GF     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  kgl_tag_t      in_tag,
  input  logic [DW-1:0] in_data,
  input  logic [GW-1:0] gain,
  output kgl_tag_t      out_tag,
  output logic [DW-1:0] out_data
);
  localparam int            PW    = DW + GW;
  localparam logic [GW-1:0] UNITY = GW'(1 << GF);
  localparam logic [DW-1:0] MAXV  = '1;

  logic [GW-1:0] gain_eff;
  logic [PW-1:0] prod;
  logic [PW-1:0] scaled;
  logic [DW-1:0] sat;

  always_comb begin
    gain_eff = (gain < UNITY) ? UNITY : gain;
    prod     = PW'(in_data) * PW'(gain_eff);
    scaled   = prod >> GF;
  end

  generate
    if (PW - GF > DW) begin : g_clip
      assign sat = (scaled > PW'(MAXV)) ? MAXV : scaled[DW-1:0];
    end else begin : g_noclip
      assign sat = DW'(scaled);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_tag  <= '0;
      out_data <= '0;
    end else begin
      out_tag  <= in_tag;
      out_data <= sat;
    end
  end

  AST_AGC_NO_SHRINK: assert property (@(posedge clk) disable iff (rst)
    in_tag.valid |=> (out_data >= $past(in_data))); // R4

  AST_AGC_UNITY: assert property (@(posedge clk) disable iff (rst)
    (in_tag.valid && (gain <= UNITY)) |=> (out_data == $past(in_data))); // R5
endmodule

// File: rtl/kgl_line_delay.sv
module kgl_line_delay
  import kgl_pkg::*;
#(
  parameter int DW    = 10,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  kgl_tag_t      in_tag,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] active,
  output kgl_tag_t      out_tag,
  output logic [DW-1:0] out_cur,
  output logic [DW-1:0] out_mem,
  output logic          out_in_range
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_now;
  logic          in_range;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] mem [DEPTH];

  always_comb begin
    idx_now  = (in_tag.valid && in_tag.sol) ? '0 : idx_q;
    in_range = (idx_now < active) && (idx_now < LIMIT);
    wr_en    = in_tag.valid && in_range;
    addr     = idx_now[AW-1:0];
  end

  // Pixel index within the line, held at LIMIT once the memory is exhausted.
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (in_tag.valid) begin
      idx_q <= (idx_now < LIMIT) ? (idx_now + 1'b1) : idx_now;
    end
  end

  // Single-port memory, read-before-write, no reset: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= in_data;
    end
    out_mem <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_tag      <= '0;
      out_cur      <= '0;
      out_in_range <= 1'b0;
    end else begin
      out_tag      <= in_tag;
      out_cur      <= in_data;
      out_in_range <= in_range;
    end
  end

  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (rst)
    (in_tag.valid && in_tag.sol) |=> (idx_q == CW'(1))); // R10

  AST_RANGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (in_tag.valid && (idx_now >= active)) |=> !out_in_range); // R7
endmodule

// File: rtl/knee_gain_line.sv
module knee_gain_line
  import kgl_pkg::*;
#(
  parameter int DW    = 10,
  parameter int GW    = 8,
  parameter int GF    = 4,
  parameter int DEPTH = 1024,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] cfg_knee,
  input  logic [GW-1:0] cfg_gain,
  input  logic [CW-1:0] cfg_active,
  output logic          out_valid,
  output logic          out_sol,
  output logic [DW-1:0] out_cur,
  output logic [DW-1:0] out_prev,
  output logic [DW:0]   out_sum
);
  kgl_tag_t      tag_in, tag_k, tag_g, tag_l;
  logic [DW-1:0] data_k, data_g, data_l, mem_l;
  logic          range_l;

  assign tag_in = '{valid: in_valid, sol: in_sol};

  kgl_inv_knee #(.DW(DW)) u_knee (
    .clk(clk), .rst(rst), .in_tag(tag_in), .in_data(in_data),
    .knee(cfg_knee), .out_tag(tag_k), .out_data(data_k)
  );

  kgl_agc #(.DW(DW), .GW(GW), .GF(GF)) u_agc (
    .clk(clk), .rst(rst), .in_tag(tag_k), .in_data(data_k),
    .gain(cfg_gain), .out_tag(tag_g), .out_data(data_g)
  );

  kgl_line_delay #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_line (
    .clk(clk), .rst(rst), .in_tag(tag_g), .in_data(data_g),
    .active(cfg_active), .out_tag(tag_l), .out_cur(data_l),
    .out_mem(mem_l), .out_in_range(range_l)
  );

  logic [DW-1:0] prev_sel;
  assign prev_sel = range_l ? mem_l : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_cur   <= '0;
      out_prev  <= '0;
      out_sum   <= '0;
    end else begin
      out_valid <= tag_l.valid;
      out_sol   <= tag_l.sol && tag_l.valid;
      if (tag_l.valid) begin
        out_cur  <= data_l;
        out_prev <= prev_sel;
        out_sum  <= {1'b0, data_l} + {1'b0, prev_sel};
      end
    end
  end

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum == ({1'b0, out_cur} + {1'b0, out_prev}))); // R8

  AST_SOL_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid); // R9

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!tag_l.valid) |=> !out_valid); // R9
endmodule

// File: tb/knee_gain_line_bench.sv
module knee_gain_line_bench;
  localparam int CLK_P = 10;
  localparam int QN    = 16384;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sol = 1'b0;
  logic [9:0]  in_data = '0;
  logic [9:0]  cfg_knee = '0;
  logic [7:0]  cfg_gain = 8'd16;
  logic [10:0] cfg_active = 11'd1024;
  logic        out_valid, out_sol;
  logic [9:0]  out_cur, out_prev;
  logic [10:0] out_sum;

  knee_gain_line u_knee_gain_line (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol), .in_data(in_data),
    .cfg_knee(cfg_knee), .cfg_gain(cfg_gain), .cfg_active(cfg_active),
    .out_valid(out_valid), .out_sol(out_sol), .out_cur(out_cur),
    .out_prev(out_prev), .out_sum(out_sum)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected output queue
  int    q_cur [QN];
  int    q_prev[QN];
  bit    q_pok [QN];
  bit    q_sol [QN];
  int    q_cyc [QN];
  string q_ct  [QN];
  string q_pt  [QN];
  int    wp = 0, rp = 0;

  // Model of line storage
  int mm [1024];
  bit mw [1024];
  int idx = 0;
  string cur_tag = "R4";
  string prev_tag = "R6";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_knee(input int x, input int k);
    return (x > k) ? (k + (x - k) / 2) : x;
  endfunction

  function automatic int f_gain(input int d, input int g);
    int ge, p;
    ge = (g < 16) ? 16 : g;
    p  = (d * ge) / 16;
    return (p > 1023) ? 1023 : p;
  endfunction

  task automatic drive(input bit v, input bit s, input int d);
    in_valid = v;
    in_sol   = s;
    in_data  = 10'(d);
    if (v) begin
      int y;
      bit inr;
      y = f_gain(f_knee(d, int'(cfg_knee)), int'(cfg_gain));
      if (s) idx = 0;
      inr = (idx < int'(cfg_active)) && (idx < 1024);
      q_cur[wp] = y;
      q_sol[wp] = s;
      q_cyc[wp] = cyc;
      q_ct[wp]  = cur_tag;
      q_pt[wp]  = inr ? prev_tag : "R7";
      q_pok[wp] = inr ? mw[idx] : 1'b1;
      q_prev[wp] = inr ? mm[idx] : 0;
      if (inr) begin
        mm[idx] = y;
        mw[idx] = 1'b1;
      end
      idx++;
      wp++;
    end
    @(negedge clk);
  endtask

  task automatic flush();
    repeat (8) drive(1'b0, 1'b0, 0);
  endtask

  // mode: 0 random, 1 ramp over full range, 2 constant full scale
  task automatic send_line(input int len, input int mode, input int idle_pct);
    for (int i = 0; i < len; i++) begin
      int d;
      while (($urandom % 100) < idle_pct)
        drive(1'b0, 1'($urandom % 2), int'($urandom % 1024));
      case (mode)
        1:       d = (i * 1024 / len) % 1024;
        2:       d = 1023;
        default: d = int'($urandom % 1024);
      endcase
      drive(1'b1, i == 0, d);
    end
  endtask

  // Output comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && out_valid && !finished) begin
      if (rp >= wp) begin
        check(1'b0, "R9", 1, 0);
      end else begin
        check(int'(out_cur) == q_cur[rp], q_ct[rp], int'(out_cur), q_cur[rp]);
        if (q_pok[rp])
          check(int'(out_prev) == q_prev[rp], q_pt[rp], int'(out_prev), q_prev[rp]);
        check(int'(out_sum) == int'(out_cur) + int'(out_prev), "R8",
              int'(out_sum), int'(out_cur) + int'(out_prev));
        check(out_sol == q_sol[rp], "R9", int'(out_sol), int'(q_sol[rp]));
        check(cyc - q_cyc[rp] == 4, "R9", cyc - q_cyc[rp], 4);
        rp++;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(out_sol == 1'b0, "R1", int'(out_sol), 0);
    check(out_cur == '0, "R1", int'(out_cur), 0);
    check(out_prev == '0, "R1", int'(out_prev), 0);
    check(out_sum == '0, "R1", int'(out_sum), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);

    // R2 and R3: ramp through a mid-scale knee at unity gain
    cfg_knee = 10'd512; cfg_gain = 8'd16; cfg_active = 11'd1024;
    cur_tag = "R3";
    send_line(300, 1, 0);
    send_line(300, 0, 20);   // R6 readback of the ramp line
    flush();
    // R3: knee at zero, every sample on the halved segment
    cfg_knee = 10'd0;
    send_line(200, 0, 10);
    flush();
    // R2: knee at full scale, every sample passes
    cur_tag = "R2";
    cfg_knee = 10'd1023;
    send_line(200, 0, 10);
    flush();
    // R5: sub-unity gain codes clamp to 1x
    cur_tag = "R5";
    cfg_knee = 10'd300; cfg_gain = 8'd0;
    send_line(150, 0, 10);
    flush();
    cfg_gain = 8'd9;
    send_line(150, 0, 10);
    flush();
    // R4: maximum gain and saturation
    cur_tag = "R4";
    cfg_gain = 8'd255;
    send_line(100, 2, 0);
    send_line(150, 0, 10);
    flush();
    cfg_gain = 8'd37; cfg_knee = 10'd700;
    send_line(150, 1, 5);
    flush();
    // R7: active count shorter than the line
    cfg_active = 11'd50;
    send_line(120, 0, 10);
    send_line(120, 0, 10);
    flush();
    // R10: short line then a long line
    cfg_active = 11'd1024;
    prev_tag = "R10";
    send_line(5, 0, 0);
    send_line(60, 0, 0);
    send_line(3, 0, 30);
    send_line(40, 0, 0);
    prev_tag = "R6";
    flush();
    // Random lines with random configuration
    for (int n = 0; n < 16; n++) begin
      cfg_knee   = 10'($urandom % 1024);
      cfg_gain   = 8'($urandom % 256);
      cfg_active = 11'(1 + ($urandom % 1100));
      for (int m = 0; m < 2; m++)
        send_line(1 + int'($urandom % 400), int'($urandom % 2), 15);
      flush();
    end
    // R7 and R6 at full memory depth
    cfg_active = 11'd1024; cfg_gain = 8'd20; cfg_knee = 10'd600;
    send_line(1030, 0, 0);
    send_line(1030, 0, 5);
    flush();
    repeat (10) @(negedge clk);
    // R9: every valid input produced exactly one output
    check(rp == wp, "R9", rp, wp);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", rp, wp);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule